// File: doc/BRIEF.md
# Global Memory Access Coalescer

The block accepts one vector load: sixteen 32-bit lane addresses together with an active-lane mask. It folds the active lanes onto the smallest set of distinct 64-byte lines and sends one line request per clock towards a cache. When each whole line comes back, it steers the right 32-bit word to every lane that touched that line. Throughput therefore depends on how many separate lines the access pattern touches, not on how many lanes are active. The order of lanes inside a line makes no difference.

The load is taken over a valid/ready handshake. The request stream and the response stream are also valid/ready. The request side holds its line address steady under back-pressure. The response side is ready only while at least one line is outstanding, and it expects responses in request order. When the last line has been taken, a one-cycle done pulse marks the lane data vector as complete. That vector then holds still until the next load is accepted. A new load is accepted only while the block is idle.

Top module: `mem_coalescer`

## Requirements
- R1: After reset, in_ready is 1, req_valid is 0, out_done is 0 and every lane of out_data is 0.
- R2: The line address of a lane is bits [31:6] of its address. One load issues exactly one request for each distinct line address among its active lanes.
- R3: Lines are requested in ascending order of the lowest-numbered active lane that references each line.
- R4: Sixteen active lanes that address consecutive words of one line, in forward or reversed lane order, produce exactly one request.
- R5: With req_ready held at 1, req_valid stays high for exactly as many consecutive cycles as there are distinct lines. An offset-by-one-word or stride-2 pattern gives 2 cycles, and a stride-16-word pattern gives 16.
- R6: Inactive lanes cause no request, and their out_data word reads 0 after the load completes.
- R7: Response word k occupies rsp_data bits [32k+31:32k]. An active lane receives word addr[5:2] of its line, and address bits [1:0] are ignored.
- R8: out_done is high for exactly one cycle, in the cycle after the last response is accepted. in_ready is 0 from acceptance until then. out_data holds its value until the next load is accepted.
- R9: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_line stays unchanged on the next cycle. Stalled responses delay completion without corrupting data.
- R10: A load with an all-zero mask issues no request and raises out_done in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load instruction valid |
| in_ready | output | 1 | Block idle, load accepted when in_valid is 1 |
| in_addr | input | 512 | Lane byte addresses, lane i in bits [32i+31:32i] |
| in_mask | input | 16 | Active-lane mask, bit i for lane i |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Cache accepts the line request |
| req_line | output | 26 | Requested line address (byte address bits [31:6]) |
| rsp_valid | input | 1 | Line data valid |
| rsp_ready | output | 1 | Block has a line outstanding and accepts data |
| rsp_data | input | 512 | Whole line, word k in bits [32k+31:32k] |
| out_data | output | 512 | Lane results, lane i in bits [32i+31:32i] |
| out_done | output | 1 | One-cycle pulse: out_data complete |

## Verification
The bench builds the block with its default values: 16 lanes, 32-bit addresses and 64-byte lines. With these values a lane's word select is a full 4-bit field, and one load can span anywhere from a single line up to sixteen lines. That range covers the one-line contiguous and reversed patterns, the two-line offset and stride cases, and the sixteen-line worst case. At that depth the group queue fills completely when responses stall while every request is already out.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [0:0] {
    CS_IDLE = 1'b0,
    CS_BUSY = 1'b1
  } coal_state_e;
endpackage

// File: rtl/coal_prio.sv
// Lowest-index set bit finder.
module coal_prio #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/coal_line_match.sv
// Marks every candidate lane whose line tag equals the reference tag.
module coal_line_match #(
  parameter int N  = 16,
  parameter int TW = 26
) (
  input  logic [N-1:0][TW-1:0] tags,
  input  logic [TW-1:0]        ref_tag,
  input  logic [N-1:0]         cand,
  output logic [N-1:0]         hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = cand[g] && (tags[g] == ref_tag);
  end
endmodule

// File: rtl/coal_word_pick.sv
// Selects one word from a returned line.
module coal_word_pick #(
  parameter int WW = 32,
  parameter int SW = 4
) (
  input  logic [(WW<<SW)-1:0] line,
  input  logic [SW-1:0]       sel,
  output logic [WW-1:0]       word
);
  assign word = line[sel*WW +: WW];
endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer #(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     in_valid,
  output logic                                     in_ready,
  input  logic [LANES*ADDR_W-1:0]                  in_addr,
  input  logic [LANES-1:0]                         in_mask,
  output logic                                     req_valid,
  input  logic                                     req_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]     req_line,
  input  logic                                     rsp_valid,
  output logic                                     rsp_ready,
  input  logic [8*LINE_BYTES-1:0]                  rsp_data,
  output logic [LANES*8*WORD_BYTES-1:0]            out_data,
  output logic                                     out_done
);
  import coal_pkg::*;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BSEL_W = $clog2(WORD_BYTES);
  localparam int WSEL_W = OFF_W - BSEL_W;
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(LANES);
  localparam int CNT_W  = $clog2(LANES + 1);

  coal_state_e                    state_q;
  logic [LANES-1:0][ADDR_W-1:0]   addr_q;
  logic [LANES-1:0]               pend_q;
  logic [LANES-1:0][WORD_W-1:0]   data_q;
  logic [LANES-1:0][TAG_W-1:0]    tags;
  logic [LANES-1:0]               grp;
  logic [LANES-1:0]               grp_fifo [LANES];
  logic [IDX_W-1:0]               pick, wr_ptr, rd_ptr;
  logic [CNT_W-1:0]               cnt_q;
  logic                           done_q, accept, push, pop;

  for (genvar g = 0; g < LANES; g++) begin : g_tag
    assign tags[g] = addr_q[g][ADDR_W-1:OFF_W];
  end

  coal_prio #(.N(LANES), .IW(IDX_W)) u_prio (.req(pend_q), .idx(pick));

  coal_line_match #(.N(LANES), .TW(TAG_W)) u_match (
    .tags(tags), .ref_tag(tags[pick]), .cand(pend_q), .hit(grp)
  );

  assign in_ready  = (state_q == CS_IDLE);
  assign accept    = in_valid && in_ready;
  assign req_valid = (state_q == CS_BUSY) && (pend_q != '0);
  assign req_line  = tags[pick];
  assign rsp_ready = (cnt_q != '0);
  assign push      = req_valid && req_ready;
  assign pop       = rsp_valid && rsp_ready;
  assign out_done  = done_q;
  assign out_data  = data_q;

  // Control, pending mask and outstanding count
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CS_IDLE;
      addr_q  <= '0;
      pend_q  <= '0;
      cnt_q   <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q <= in_addr;
        pend_q <= in_mask;
        if (in_mask == '0) done_q  <= 1'b1;
        else               state_q <= CS_BUSY;
      end
      if (push) begin
        pend_q <= pend_q & ~grp;
        wr_ptr <= (wr_ptr == IDX_W'(LANES - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        rd_ptr <= (rd_ptr == IDX_W'(LANES - 1)) ? '0 : rd_ptr + 1'b1;
        if (pend_q == '0 && cnt_q == CNT_W'(1)) begin
          done_q  <= 1'b1;
          state_q <= CS_IDLE;
        end
      end
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // Lane groups waiting for their line, in request order
  always_ff @(posedge clk) begin
    if (push) grp_fifo[wr_ptr] <= grp;
  end

  // Per-lane result capture
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] word;
    coal_word_pick #(.WW(WORD_W), .SW(WSEL_W)) u_pick (
      .line(rsp_data), .sel(addr_q[g][OFF_W-1:BSEL_W]), .word(word)
    );
    always_ff @(posedge clk) begin
      if (rst || accept)                   data_q[g] <= '0;
      else if (pop && grp_fifo[rd_ptr][g]) data_q[g] <= word;
    end
  end
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int LANES  = 16,
  parameter int TAG_W  = 26,
  parameter int DATA_W = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LANES-1:0]  in_mask,
  input logic              req_valid,
  input logic              req_ready,
  input logic [TAG_W-1:0]  req_line,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_done
);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_line));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);

  a_r8_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid || rsp_ready) |-> !in_ready);

  a_r10_empty_done: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_mask == '0) |=> out_done && !req_valid);

  a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) && !(rsp_valid && rsp_ready) |=> $stable(out_data));
endmodule

bind mem_coalescer coal_chk #(
  .LANES(LANES), .TAG_W(ADDR_W - $clog2(LINE_BYTES)), .DATA_W(LANES*8*WORD_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_mask(in_mask), .req_valid(req_valid), .req_ready(req_ready),
  .req_line(req_line), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .out_data(out_data), .out_done(out_done)
);

// File: tb/mem_coalescer_tb.sv
module mem_coalescer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [NL*32-1:0] in_addr = '0;
  logic [NL-1:0] in_mask = '0;
  logic req_valid, req_ready = 1'b1;
  logic [25:0] req_line;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [511:0] rsp_data = '0;
  logic [NL*32-1:0] out_data;
  logic out_done;

  mem_coalescer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_mask(in_mask), .req_valid(req_valid),
    .req_ready(req_ready), .req_line(req_line), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .out_data(out_data),
    .out_done(out_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_issued = 0, reqv_cycles = 0, hold_err = 0, ready_err = 0;
  int wait_cycles = 0, done_w = 0;
  bit stall = 1'b0, busy = 1'b0, hold_pend = 1'b0;
  logic [25:0] hold_line;
  logic [25:0] issued [NL];
  logic [25:0] q [$];
  logic [31:0] stim [NL];
  logic [NL*32-1:0] snap;

  function automatic logic [31:0] mem_word(input logic [29:0] wa);
    return ({2'b00, wa} * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [511:0] mem_line(input logic [25:0] ln);
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = mem_word({ln, 4'(k)});
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cache model and monitors; inputs change at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      req_ready = stall ? cyc[0] : 1'b1;
      if (q.size() > 0 && (!stall || (cyc % 3 != 0))) begin
        rsp_valid = 1'b1;
        rsp_data  = mem_line(q[0]);
      end else begin
        rsp_valid = 1'b0;
      end
      if (hold_pend && (!req_valid || req_line != hold_line)) hold_err++;
      hold_pend = req_valid && !req_ready;
      hold_line = req_line;
      if (req_valid) reqv_cycles++;
      if (req_valid && req_ready) begin
        q.push_back(req_line);
        if (n_issued < NL) issued[n_issued] = req_line;
        n_issued++;
      end
      if (rsp_valid && rsp_ready) void'(q.pop_front());
      if (busy && in_ready && !out_done) ready_err++;
    end
  end

  // Runs one load from stim/mask and checks lines, order and data
  task automatic run_load(input logic [NL-1:0] mask, input string tag, input int exp_cycles);
    logic [25:0] exp_l [NL];
    int ne = 0;
    bit seen;
    for (int i = 0; i < NL; i++) begin
      if (mask[i]) begin
        seen = 1'b0;
        for (int j = 0; j < ne; j++) if (exp_l[j] == stim[i][31:6]) seen = 1'b1;
        if (!seen) begin exp_l[ne] = stim[i][31:6]; ne++; end
      end
    end
    @(negedge clk); #1;
    n_issued = 0; reqv_cycles = 0; hold_err = 0; ready_err = 0;
    for (int i = 0; i < NL; i++) in_addr[i*32 +: 32] = stim[i];
    in_mask = mask;
    in_valid = 1'b1;
    @(negedge clk); #1;
    in_valid = 1'b0;
    busy = 1'b1;
    wait_cycles = 0;
    while (!out_done && wait_cycles < 3000) begin
      @(negedge clk); #1;
      wait_cycles++;
    end
    busy = 1'b0;
    chk(out_done == 1'b1, {tag, " R8 done seen"}, out_done, 1);
    snap = out_data;
    chk(n_issued == ne, {tag, " R2 line count"}, n_issued, ne);
    for (int j = 0; j < ne && j < n_issued; j++)
      chk(issued[j] == exp_l[j], {tag, " R3 line order"}, issued[j], exp_l[j]);
    if (exp_cycles >= 0)
      chk(reqv_cycles == exp_cycles, {tag, " R5 request cycles"}, reqv_cycles, exp_cycles);
    for (int i = 0; i < NL; i++) begin
      logic [31:0] e;
      e = mask[i] ? mem_word(stim[i][31:2]) : 32'h0;
      chk(out_data[i*32 +: 32] == e, {tag, (mask[i] ? " R7 lane data" : " R6 inactive lane zero")},
          out_data[i*32 +: 32], e);
    end
    chk(ready_err == 0, {tag, " R8 in_ready low while busy"}, ready_err, 0);
    chk(hold_err == 0, {tag, " R9 request hold"}, hold_err, 0);
    @(negedge clk); #1;
    chk(out_done == 1'b0, {tag, " R8 done one cycle"}, out_done, 0);
    @(negedge clk); #1;
    @(negedge clk); #1;
    chk(out_data == snap, {tag, " R8 data held"}, 0, 0);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
    chk(out_done == 1'b0, "R1 out_done", out_done, 0);
    chk(out_data == '0, "R1 out_data", 0, 0);
  endtask

  task automatic t_contig();
    for (int i = 0; i < NL; i++) stim[i] = 32'h0000_1000 + 32'(4*i);
    run_load('1, "contig R4", 1);
  endtask

  task automatic t_reverse();
    for (int i = 0; i < NL; i++) stim[i] = 32'h0000_2040 + 32'(4*(15-i));
    run_load('1, "reverse R4", 1);
  endtask

  task automatic t_offset();
    for (int i = 0; i < NL; i++) stim[i] = 32'h0000_3000 + 32'(4*(i+1));
    run_load('1, "offset R5", 2);
  endtask

  task automatic t_stride2();
    for (int i = 0; i < NL; i++) stim[i] = 32'h0000_4000 + 32'(8*i);
    run_load('1, "stride2 R5", 2);
  endtask

  task automatic t_stride16();
    for (int i = 0; i < NL; i++) stim[i] = 32'h0001_0000 + 32'(64*i);
    run_load('1, "stride16 R5", 16);
  endtask

  task automatic t_mask();
    for (int i = 0; i < NL; i++) stim[i] = 32'h0002_0000 + 32'(64*i);
    run_load(16'h0F0A, "masked R6", 6);
  endtask

  task automatic t_order();
    // Scattered lines; low two address bits set to show R7 ignores them
    for (int i = 0; i < NL; i++)
      stim[i] = 32'h0005_0000 + 32'(((7*i) % 5) * 64) + 32'(4*((3*i) % 16)) + 32'(i % 4);
    run_load('1, "order R3", 5);
  endtask

  task automatic t_empty();
    for (int i = 0; i < NL; i++) stim[i] = 32'h0006_0000 + 32'(64*i);
    run_load('0, "empty R10", 0);
    chk(wait_cycles == 0, "R10 done next cycle", wait_cycles, 0);
  endtask

  task automatic t_stall();
    stall = 1'b1;
    for (int i = 0; i < NL; i++) stim[i] = 32'h0007_0000 + 32'(64*((i*5) % 16)) + 32'(4*i);
    run_load('1, "stall R9", -1);
    stall = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_contig();
    t_reverse();
    t_offset();
    t_stride2();
    t_stride16();
    t_mask();
    t_order();
    t_empty();
    t_stall();
    t_contig();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule